// File: doc/BRIEF.md
# Wake-up and watchdog supervisor

This block watches over a microcontroller that spends most of its time asleep. It drives a periodic wake-up square wave. Every rising edge of that wave asks the processor to run briefly and answer with a watchdog pulse. The block also drives an active-low reset.

The first falling edge of the watchdog input in a wake-up cycle cuts the wake-up output short and marks the cycle as served. A cycle that ends with no answer produces a reset pulse. A supply-good flag keeps the reset asserted for as long as regulation is lost. When the flag returns, the reset is released after a delay, and wake-up cycling resumes after a second delay.

All timing comes from one time-base parameter, `UNIT_CYC`, given in clock cycles. Every duration is a fixed multiple of it:

| Duration | Length in units |
|---|---|
| Wake-up period | 8 |
| Reset delay | 1 |
| Reset-release-to-wake delay | 4 |

The supply-good flag is assumed to be synchronous to `clk`. The watchdog input is treated as asynchronous.

Top module: `wake_wdog_supervisor`

## Requirements
- R1: While cycling, `wake_out` (active high) rises once every 8·UNIT_CYC clocks. In a cycle with no watchdog answer it stays high for exactly 4·UNIT_CYC clocks and then low for 4·UNIT_CYC clocks.
- R2: The first falling edge of `wdog_in` inside a wake-up cycle drives `wake_out` low on the third rising clock edge after the input falls. This covers two synchronizer stages and one register. `wake_out` then stays low until the next cycle begins, and that cycle begins on schedule with no reset.
- R3: Further falling edges of `wdog_in` within a cycle that has already been answered change nothing. The cycle timing is unchanged, and they do not count as an answer for the following cycle.
- R4: If no watchdog edge is registered during a wake-up cycle, `sup_rst_n` goes low on the clock edge that ends the cycle. It stays low for UNIT_CYC clocks. An edge registered on that final clock edge still counts for the ending cycle; one registered a clock later does not.
- R5: `sup_rst_n` (active low) is low while `pwr_good` is 0. Once `pwr_good` is sampled as 1, `sup_rst_n` goes high on the (UNIT_CYC+1)-th rising clock edge.
- R6: After `sup_rst_n` rises, `wake_out` rises 4·UNIT_CYC clocks later. `wake_out` is low whenever `sup_rst_n` is low.
- R7: When `pwr_good` is sampled as 0, both `sup_rst_n` and `wake_out` are low after that clock edge, and they stay low while `pwr_good` stays 0.
- R8: Watchdog edges that arrive while reset is asserted or during the release-to-wake delay do not count as an answer for the next wake-up cycle.
- R9: Asserting `rst_n` low forces `sup_rst_n` and `wake_out` low at once, without waiting for a clock. Its release passes through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pwr_good | input | 1 | Supply-in-regulation flag, 1 = good |
| wdog_in | input | 1 | Watchdog input from the processor; falling edges count |
| wake_out | output | 1 | Wake-up square wave, active high |
| sup_rst_n | output | 1 | Supervisor reset to the processor, active low |

## Verification
The end of a wake-up cycle and the registration of a watchdog edge can fall on the same clock edge. In that case the block must decide between a new cycle and a reset pulse using an answer that is still arriving. The bench waits for the falling edge of the wake-up wave and then drives the watchdog input low exactly three clocks before the cycle ends, so that the synchronized edge lands on the closing clock edge. It expects a clean new rising edge and no reset. It then repeats the stimulus one clock later and expects the reset pulse to start on the closing edge.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Duration multiples of the time base
  localparam int unsigned RST_UNITS  = 1;
  localparam int unsigned WDLY_UNITS = 4;
  localparam int unsigned HALF_UNITS = 4;

  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,  // regulation lost or power-up
    ST_RDLY = 3'd1,  // reset still low, counting reset delay
    ST_WDLY = 3'd2,  // reset released, waiting before cycling
    ST_HI   = 3'd3,  // first half of a wake-up cycle
    ST_LO   = 3'd4   // second half of a wake-up cycle
  } sup_state_e;

endpackage

// File: rtl/sup_rst_sync.sv
module sup_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/sup_wd_edge.sv
module sup_wd_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_in,
  output logic wd_fall
);

  // Stages 0..SYNC_STAGES-1 synchronize; the last stage holds the previous value
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else begin
      sh_q[0] <= wd_in;
      for (int i = 1; i <= SYNC_STAGES; i++) begin
        sh_q[i] <= sh_q[i-1];
      end
    end
  end

  assign wd_fall = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];

endmodule

// File: rtl/sup_interval_timer.sv
module sup_interval_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sup_seq_fsm.sv
module sup_seq_fsm
  import sup_pkg::*;
#(
  parameter int unsigned RST_CYC  = 1,
  parameter int unsigned WDLY_CYC = 4,
  parameter int unsigned HALF_CYC = 4,
  parameter int unsigned CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             wd_fall,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             wake_q,
  output logic             rstn_q
);

  localparam logic [CNT_W-1:0] RST_LD  = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] WDLY_LD = CNT_W'(WDLY_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYC - 1);

  sup_state_e state_q, state_d;
  logic       state_en;
  logic       seen_q, seen_d;
  logic       wake_d, rstn_d;
  logic       cyc_active, wd_hit, new_cycle;

  // Next-state logic
  always_comb begin
    cyc_active = (state_q == ST_HI) || (state_q == ST_LO);
    wd_hit     = cyc_active && wd_fall;
    state_d    = state_q;
    unique case (state_q)
      ST_HOLD: if (pwr_good) state_d = ST_RDLY;
      ST_RDLY: if (tmr_done) state_d = ST_WDLY;
      ST_WDLY: if (tmr_done) state_d = ST_HI;
      ST_HI:   if (tmr_done) state_d = ST_LO;
      ST_LO:   if (tmr_done) state_d = (seen_q || wd_hit) ? ST_HI : ST_RDLY;
      default: state_d = ST_HOLD;
    endcase
    if (!pwr_good) state_d = ST_HOLD;
    state_en = (state_d != state_q);
  end

  // Per-cycle answer flag and registered outputs
  always_comb begin
    new_cycle = (state_d == ST_HI) && (state_q != ST_HI);
    if (new_cycle || !((state_d == ST_HI) || (state_d == ST_LO))) begin
      seen_d = 1'b0;
    end else if (wd_hit) begin
      seen_d = 1'b1;
    end else begin
      seen_d = seen_q;
    end
    wake_d = (state_d == ST_HI) && !seen_d;
    rstn_d = !((state_d == ST_HOLD) || (state_d == ST_RDLY));
  end

  // Timer reload on every state entry
  always_comb begin
    tmr_load = state_en;
    unique case (state_d)
      ST_RDLY:      tmr_val = RST_LD;
      ST_WDLY:      tmr_val = WDLY_LD;
      ST_HI, ST_LO: tmr_val = HALF_LD;
      default:      tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      wake_q <= 1'b0;
      rstn_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
      wake_q <= wake_d;
      rstn_q <= rstn_d;
    end
  end

endmodule

// File: rtl/wake_wdog_supervisor.sv
module wake_wdog_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned UNIT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic wdog_in,
  output logic wake_out,
  output logic sup_rst_n
);

  localparam int unsigned RST_CYC  = RST_UNITS * UNIT_CYC;
  localparam int unsigned WDLY_CYC = WDLY_UNITS * UNIT_CYC;
  localparam int unsigned HALF_CYC = HALF_UNITS * UNIT_CYC;
  localparam int unsigned MAX_A    = (RST_CYC > WDLY_CYC) ? RST_CYC : WDLY_CYC;
  localparam int unsigned MAX_CYC  = (MAX_A > HALF_CYC) ? MAX_A : HALF_CYC;
  localparam int unsigned CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic             rst_sync_n;
  logic             wd_fall;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;

  sup_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sup_wd_edge #(.SYNC_STAGES(2)) u_wd_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wd_in   (wdog_in),
    .wd_fall (wd_fall)
  );

  sup_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sup_seq_fsm #(
    .RST_CYC  (RST_CYC),
    .WDLY_CYC (WDLY_CYC),
    .HALF_CYC (HALF_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pwr_good (pwr_good),
    .wd_fall  (wd_fall),
    .tmr_done (tmr_done),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .wake_q   (wake_out),
    .rstn_q   (sup_rst_n)
  );

endmodule

// File: rtl/wake_wdog_supervisor_chk.sv
module wake_wdog_supervisor_chk #(
  parameter int unsigned HALF_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic wd_fall,
  input logic wake_out,
  input logic sup_rst_n
);

  int unsigned hi_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= 0;
    end else if (wake_out) begin
      hi_run_q <= hi_run_q + 1;
    end else begin
      hi_run_q <= 0;
    end
  end

  AST_HIGH_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wake_out |-> (hi_run_q < HALF_CYC)); // R1

  AST_WD_CUTS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fall && wake_out) |=> !wake_out); // R2

  AST_RELEASE_NEEDS_PG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_rst_n) |-> $past(pwr_good)); // R5

  AST_WAKE_QUIET_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_rst_n |-> !wake_out); // R6

  AST_WAKE_RISE_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_out) |-> $past(sup_rst_n)); // R6

  AST_PG_DROP_RST: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!sup_rst_n && !wake_out)); // R7

endmodule

bind wake_wdog_supervisor wake_wdog_supervisor_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_good  (pwr_good),
  .wd_fall   (wd_fall),
  .wake_out  (wake_out),
  .sup_rst_n (sup_rst_n)
);

// File: tb/tb_wake_wdog_supervisor.sv
`timescale 1ns/1ps
module tb_wake_wdog_supervisor;

  localparam int UNIT = 4;
  localparam int RSTC = UNIT;
  localparam int WDLY = 4 * UNIT;
  localparam int HALF = 4 * UNIT;
  localparam int PER  = 2 * HALF;

  logic clk = 1'b0;
  logic rst_n, pwr_good, wdog_in;
  logic wake_out, sup_rst_n;

  int tot = 0;
  int fails = 0;
  int el = 0;
  bit rst_low_seen = 1'b0;

  always #5 clk = ~clk;

  wake_wdog_supervisor #(.UNIT_CYC(UNIT)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .wdog_in   (wdog_in),
    .wake_out  (wake_out),
    .sup_rst_n (sup_rst_n)
  );

  always @(negedge clk) if (sup_rst_n === 1'b0) rst_low_seen = 1'b1;

  task automatic chk(input string req, input int act, input int exp);
    tot++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    el += n;
  endtask

  // which: 0 = wake_out, 1 = sup_rst_n
  task automatic wait_val(input int which, input logic v, input int lim, output int n);
    n = lim + 1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if ((which == 0 ? wake_out : sup_rst_n) === v) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic pulse();
    wdog_in = 1'b0;
    tick(3);
    wdog_in = 1'b1;
    tick(3);
  endtask

  task automatic bring_up();
    int n;
    pwr_good = 1'b0;
    wdog_in  = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    pwr_good = 1'b1;
    wait_val(1, 1'b1, 100, n);
    wait_val(0, 1'b1, 100, n);
    el = 0;
    rst_low_seen = 1'b0;
  endtask

  task automatic t_reset_state();
    pwr_good = 1'b0;
    wdog_in  = 1'b1;
    rst_n    = 1'b0;
    #1;
    chk("R9 wake in reset", int'(wake_out), 0);
    chk("R9 sup_rst_n in reset", int'(sup_rst_n), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R5 held low without pwr_good", int'(sup_rst_n), 0);
  endtask

  task automatic t_powerup();
    int n;
    pwr_good = 1'b1;
    wait_val(1, 1'b1, 100, n);
    chk("R5 reset delay", n, RSTC + 1);
    wait_val(0, 1'b1, 100, n);
    chk("R6 release-to-wake delay", n, WDLY);
    wait_val(0, 1'b0, 100, n);
    chk("R1 unanswered high time", n, HALF);
    wait_val(1, 1'b0, 100, n);
    chk("R4 missed cycle reset at cycle end", n, HALF);
    chk("R6 wake low in reset", int'(wake_out), 0);
    wait_val(1, 1'b1, 100, n);
    chk("R4 reset pulse width", n, RSTC);
    wait_val(0, 1'b1, 100, n);
    chk("R6 wake delay after pulse", n, WDLY);
  endtask

  task automatic t_served();
    int n;
    bring_up();
    tick(2);
    wdog_in = 1'b0;
    tick(2);
    chk("R2 wake still high before sync", int'(wake_out), 1);
    tick(1);
    chk("R2 wake cut on third edge", int'(wake_out), 0);
    wdog_in = 1'b1;
    wait_val(0, 1'b1, 100, n);
    chk("R1 period with answer", n, PER - el);
    chk("R2 no reset when answered", int'(rst_low_seen), 0);
  endtask

  task automatic t_multi();
    int n;
    bring_up();
    tick(2);
    pulse();
    pulse();
    tick(20 - el);
    pulse();
    chk("R3 wake stays low", int'(wake_out), 0);
    wait_val(0, 1'b1, 100, n);
    chk("R3 extra edges keep period", n, PER - el);
    chk("R3 no reset in answered cycle", int'(rst_low_seen), 0);
    wait_val(1, 1'b0, 100, n);
    chk("R3 extra edges not carried over", n, PER);
  endtask

  task automatic t_boundary();
    int n;
    bring_up();
    wait_val(0, 1'b0, 100, n);
    tick(HALF - 3);
    wdog_in = 1'b0;
    wait_val(0, 1'b1, 100, n);
    chk("R4 edge on final clock counts", n, 3);
    wdog_in = 1'b1;
    chk("R4 no reset on boundary answer", int'(rst_low_seen), 0);
    wait_val(0, 1'b0, 100, n);
    chk("R1 high time after boundary", n, HALF);
    tick(HALF - 2);
    wdog_in = 1'b0;
    wait_val(1, 1'b0, 100, n);
    chk("R4 edge one clock late misses", n, 2);
    chk("R4 wake low after late edge", int'(wake_out), 0);
    wdog_in = 1'b1;
  endtask

  task automatic t_outside();
    int n;
    pwr_good = 1'b0;
    wdog_in  = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    pwr_good = 1'b1;
    tick(1);
    pulse();
    wait_val(1, 1'b1, 100, n);
    tick(2);
    pulse();
    wait_val(0, 1'b1, 100, n);
    wait_val(1, 1'b0, 100, n);
    chk("R8 edges before cycling not counted", n, PER);
  endtask

  task automatic t_pgloss();
    int n;
    bring_up();
    tick(3);
    pwr_good = 1'b0;
    tick(1);
    chk("R7 reset low after pwr loss", int'(sup_rst_n), 0);
    chk("R7 wake low after pwr loss", int'(wake_out), 0);
    tick(10);
    chk("R7 reset held while pwr low", int'(sup_rst_n), 0);
    pwr_good = 1'b1;
    wait_val(1, 1'b1, 100, n);
    chk("R5 reset delay after recovery", n, RSTC + 1);
  endtask

  task automatic t_async();
    bring_up();
    tick(3);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R9 async wake clear", int'(wake_out), 0);
    chk("R9 async reset out", int'(sup_rst_n), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    pwr_good = 1'b0;
    wdog_in = 1'b1;
    t_reset_state();
    t_powerup();
    t_served();
    t_multi();
    t_boundary();
    t_outside();
    t_pgloss();
    t_async();
    $display("%0d/%0d checks passed", tot - fails, tot);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tot++;
    fails++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("%0d/%0d checks passed", tot - fails, tot);
    $finish;
  end

endmodule